// File: doc/BRIEF.md
# Ping-Pong Line Reverser

This block turns a stream of samples around one line at a time, so that a symmetric filter can fold each sample against its mirror partner. It holds two last-in first-out stacks. While one stack collects the samples arriving on the forward input, the other gives back the previous line, newest sample first, on the reverse output. The roles of the two stacks trade places at line boundaries.

A line boundary is marked by a falling edge on the swap control. The control is registered every cycle. A swap happens on the clock edge where the registered copy is high and the freshly sampled input is low. A steady level on the control, high or low, never swaps. An active-low shift enable moves the data. While the enable is low, each clock edge pushes one forward sample and pops one reverse sample. While it is high, both stacks and the reverse output hold.

Top module: `pingpong_reverser`

## Requirements
- R1: After reset, `rev_data` is 0, stack 0 is the receiver, both stacks are empty and the registered swap control is low. A swap therefore first needs the control to be sampled high and then low.
- R2: On an edge where `shift_n` is low and no swap occurs, `fwd_data` is pushed onto the receiving stack. Successive pushes append in arrival order.
- R3: On such an edge, the top word of the sending stack is popped into the `rev_data` register. A line of N words written into a stack therefore comes out as word N-1 first and word 0 last.
- R4: Popping an empty sending stack loads 0 into `rev_data` and leaves that stack unchanged.
- R5: A swap occurs on a rising clock edge where the previously registered `swap_ctl` is 1 and the sampled `swap_ctl` is 0, whatever the level of `shift_n`. On that edge the stacks exchange roles, nothing is pushed or popped, and `rev_data` holds.
- R6: Holding `swap_ctl` at a constant level, high or low, for any number of cycles causes no swap.
- R7: On a swap, the stack that becomes the receiver is emptied. The stack that becomes the sender keeps its words and pops from the last word written.
- R8: While `shift_n` is 1, no word is pushed or popped and `rev_data` keeps its value.
- R9: A stack holds at most DEPTH words (default 256). Pushes into a full receiver are dropped and the first DEPTH words of the line are kept.
- R10: The sample width is a parameter, WIDTH, with a default of 12 bits for both data ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_data | input | WIDTH | Forward sample input |
| swap_ctl | input | 1 | Role-swap control; a high-to-low transition swaps the stacks |
| shift_n | input | 1 | Active-low shift enable |
| rev_data | output | WIDTH | Registered reversed sample output |

## Verification
Each stack's pointer sits behind the reverse port, so a wrong pointer shows within one line. A lost or extra push shifts every word of the next reversed line by one position. A pointer that is not cleared on a swap leaves stale words in front of the new line. A spurious or missed swap makes the reverse output either restart on the wrong line or fall to zeros in the first cycle after the bad edge. A hold fault on the shift enable shows as a changed `rev_data` in the same cycle, and as a one-word slip in the line that follows.

// File: rtl/prv_pkg.sv
package prv_pkg;
  localparam int unsigned NUM_STACKS = 2;

  // Which stack currently receives from the forward path
  typedef enum logic {
    RX_STACK0 = 1'b0,
    RX_STACK1 = 1'b1
  } rx_sel_e;
endpackage

// File: rtl/prv_swap_detect.sv
module prv_swap_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_in,
  output logic ctl_q,
  output logic fall
);
  logic ctl_d;

  always_comb begin
    ctl_d = ctl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= 1'b0;
    else        ctl_q <= ctl_d;
  end

  // High-to-low seen between the registered copy and the new sample
  assign fall = ctl_q & ~ctl_in;
endmodule

// File: rtl/prv_lifo_stack.sv
module prv_lifo_stack #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] top_word,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PTR_FULL = PW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    ptr_q, ptr_d;
  logic [PW-1:0]    rd_ptr;

  always_comb begin
    ptr_d = ptr_q;
    if (clear)     ptr_d = '0;
    else if (push) ptr_d = ptr_q + 1'b1;
    else if (pop)  ptr_d = ptr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // Storage carries no reset; only words below the pointer are ever read
  always_ff @(posedge clk) begin
    if (push) mem[ptr_q[AW-1:0]] <= din;
  end

  assign rd_ptr   = ptr_q - 1'b1;
  assign empty    = (ptr_q == '0);
  assign full     = (ptr_q == PTR_FULL);
  assign top_word = empty ? '0 : mem[rd_ptr[AW-1:0]];

  p_push_has_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_pop_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);
  p_clear_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !(push || pop));
  p_ptr_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_FULL);
endmodule

// File: rtl/pingpong_reverser.sv
module pingpong_reverser
  import prv_pkg::*;
#(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] fwd_data,
  input  logic             swap_ctl,
  input  logic             shift_n,
  output logic [WIDTH-1:0] rev_data
);
  rx_sel_e          sel_q, sel_d;
  logic             ctl_q;
  logic             fall;
  logic             advance;
  logic [WIDTH-1:0] rev_q, rev_d;

  logic [NUM_STACKS-1:0] push, pop, clear, empty, full;
  logic [WIDTH-1:0]      top_word [NUM_STACKS];

  logic [WIDTH-1:0] snd_word;
  logic             snd_empty;
  logic             rx_empty;

  prv_swap_detect u_swap (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_in (swap_ctl),
    .ctl_q  (ctl_q),
    .fall   (fall)
  );

  assign advance = ~shift_n & ~fall;

  for (genvar gi = 0; gi < NUM_STACKS; gi++) begin : g_stack
    logic is_rx;
    assign is_rx     = (sel_q == rx_sel_e'(gi));
    assign push[gi]  = advance &  is_rx & ~full[gi];
    assign pop[gi]   = advance & ~is_rx & ~empty[gi];
    assign clear[gi] = fall    & ~is_rx;

    prv_lifo_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push[gi]),
      .pop      (pop[gi]),
      .clear    (clear[gi]),
      .din      (fwd_data),
      .top_word (top_word[gi]),
      .empty    (empty[gi]),
      .full     (full[gi])
    );
  end

  always_comb begin
    if (sel_q == RX_STACK0) begin
      snd_word  = top_word[1];
      snd_empty = empty[1];
      rx_empty  = empty[0];
    end else begin
      snd_word  = top_word[0];
      snd_empty = empty[0];
      rx_empty  = empty[1];
    end
  end

  always_comb begin
    sel_d = sel_q;
    if (fall) sel_d = (sel_q == RX_STACK0) ? RX_STACK1 : RX_STACK0;
  end

  always_comb begin
    rev_d = rev_q;
    if (advance) rev_d = snd_empty ? '0 : snd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= RX_STACK0;
      rev_q <= '0;
    end else begin
      sel_q <= sel_d;
      rev_q <= rev_d;
    end
  end

  assign rev_data = rev_q;

  p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_n |=> $stable(rev_data));
  p_swap_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q && !swap_ctl) |=> (sel_q != $past(sel_q)));
  p_level_no_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q && !swap_ctl) |=> $stable(sel_q));
  p_empty_pop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && snd_empty) |=> (rev_data == '0));
  p_rx_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> rx_empty);
  p_one_pusher_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push) && $onehot0(pop));
  p_swap_holds_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> $stable(rev_data));
endmodule

// File: tb/pingpong_reverser_test.sv
module pingpong_reverser_test;
  localparam int unsigned W = 12;
  localparam int unsigned D = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] fwd_data;
  logic         swap_ctl;
  logic         shift_n;
  logic [W-1:0] rev_data;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  pingpong_reverser #(.WIDTH(W), .DEPTH(D)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_data (fwd_data),
    .swap_ctl (swap_ctl),
    .shift_n  (shift_n),
    .rev_data (rev_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rev_data=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge
  task automatic cyc(input logic [W-1:0] d, input logic sc, input logic sh);
    fwd_data = d;
    swap_ctl = sc;
    shift_n  = sh;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pbase, base, last;
    int plen;
    rst_n = 1'b0; fwd_data = '0; swap_ctl = 1'b0; shift_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset value", rev_data, '0);

    // R1: the control reset low, so a low right after reset must not swap.
    // Push three words into stack 0 with the control held low; the empty sender gives zeros (R4).
    for (int i = 0; i < 3; i++) begin
      cyc(12'h0A0 + W'(i), 1'b0, 1'b0);
      check("R1/R4 empty sender pops zero", rev_data, '0);
    end
    // R5: a swap on a high-to-low transition; stack 0 with its 3 words becomes the sender
    cyc('0, 1'b1, 1'b1);
    cyc('0, 1'b0, 1'b0);
    check("R5 swap edge holds output", rev_data, '0);
    for (int i = 0; i < 4; i++) begin
      cyc('0, 1'b1, 1'b0);
      check("R1/R3 first line reversed", rev_data, (i < 3) ? 12'h0A2 - W'(i) : '0);
    end
    // Close this line (4 zero words pushed) with a swap
    cyc('0, 1'b0, 1'b0);
    plen = 4; pbase = '0;
    last = rev_data;

    // Sweep line lengths 0..D+2; each line pops the previous one while it is pushed
    for (int L = 0; L <= D + 2; L++) begin
      base = W'(L * 37 + 100);
      for (int i = 0; i < L; i++) begin
        if (i == 2 && (L % 2) == 1) begin
          cyc(12'hFFF, 1'b1, 1'b1);
          check("R8 shift off holds output", rev_data, last);
        end
        cyc(base + W'(i), 1'b1, 1'b0);
        if (i < plen) check("R3 line comes out reversed", rev_data, pbase + W'(plen - 1 - i));
        else          check("R4 drained sender gives zero", rev_data, '0);
        last = rev_data;
      end
      // One idle cycle, then the swap edge (R5, R7, R9)
      cyc('0, 1'b1, 1'b1);
      check("R8 idle holds", rev_data, last);
      cyc(12'h555, 1'b0, 1'b0);
      check("R5 swap edge holds", rev_data, last);
      plen = (L < D) ? L : D;
      pbase = base;
    end

    // R6: after the last swap, keep the control low; pushes accumulate in one receiver
    for (int i = 0; i < 3; i++) begin
      cyc(12'h300 + W'(i), 1'b0, 1'b0);
      check("R6 low level no swap, R9 first words kept", rev_data, pbase + W'(plen - 1 - i));
    end
    for (int i = 0; i < 2; i++) begin
      cyc('0, 1'b0, 1'b1);
      check("R6/R8 low level idle", rev_data, pbase + W'(plen - 3));
    end
    for (int i = 0; i < 2; i++) begin
      cyc(12'h310 + W'(i), 1'b0, 1'b0);
      check("R6 still no swap", rev_data, pbase + W'(plen - 4 - i));
    end
    // R6: held high as well
    cyc('0, 1'b1, 1'b1);
    cyc('0, 1'b1, 1'b1);
    check("R6 high level no swap", rev_data, pbase + W'(plen - 5));
    // R5: swap with shift disabled still swaps
    cyc('0, 1'b0, 1'b1);
    check("R5 swap while shift off holds", rev_data, pbase + W'(plen - 5));
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] e;
      case (i)
        0: e = 12'h311;
        1: e = 12'h310;
        2: e = 12'h302;
        3: e = 12'h301;
        4: e = 12'h300;
        default: e = '0;
      endcase
      cyc('0, 1'b0, 1'b0);
      check("R2/R7 pops start at last written", rev_data, e);
    end

    // R1: reset mid-stream returns the output to zero
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears output", rev_data, '0);
    rst_n = 1'b1;
    // R10: full-width value passes through
    cyc(12'hFFF, 1'b1, 1'b0);
    cyc('0, 1'b0, 1'b0);
    cyc('0, 1'b1, 1'b0);
    check("R10 full 12-bit word", rev_data, 12'hFFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule